// File: doc/BRIEF.md
# Instruction Cycle State Sequencer

This block is the control sequencer of a small processor. It steps through one instruction at a time: it forms the fetch address, reads the instruction word into an instruction register and decodes it. Then it runs the operand steps that the instruction asks for: operand address calculation, operand read, data operation, address calculation on the store side, and operand store. Each instruction ends in an interrupt-check state. There the sequencer either goes on to the next fetch or diverts to a fixed handler address after it saves the program counter and flags.

The instruction word is 14 bits wide at the default parameters. Bits [13:10] hold the opcode, bits [9:8] hold the operand mode, bits [7:0] hold a jump target and bits [3:0] hold an element count. The count field overlaps the target field; a jump does not use a count. The sequencer reports its position as a one-hot phase vector, drives read and write strobes for the memory or I/O handshake, and holds every memory step until the ready input is high. The arithmetic datapath and bus arbitration are outside the block: it takes operation flags from the datapath in and gives control strobes out.

Top module: `instr_cycle_seq`

## Requirements
- R1: `phase` is always one-hot. Bit 0 is next-address calculation, 1 instruction fetch, 2 decode, 3 read-side operand address, 4 operand fetch, 5 data operation, 6 write-side operand address, 7 operand store and 8 interrupt check.
- R2: After decode, mode bits [9:8] select the operand path: 0 runs the operation only, 1 runs read address, operand fetch and operation, 2 runs operation, write address and store, 3 runs all five. The interrupt check follows.
- R3: In the fetch phase `mem_rd` is high. When `mem_ready` is high, the word on `mem_rdata` is taken as the instruction and `pc` advances by one on that edge.
- R4: Fetch, operand fetch and store stay in place for as long as `mem_ready` is low and leave on the edge where it is high. Every other phase lasts exactly one clock.
- R5: For an ordinary instruction with count field [3:0] = n, the operand steps selected by the mode run n+1 times before the interrupt check.
- R6: Opcode 8 loads `pc` with bits [7:0] at decode and goes straight to the interrupt check, whatever the mode bits hold.
- R7: If `irq` is high in the interrupt check while no handler is active, `irq_ack` pulses for that one clock. The current `pc` and `flags` are saved, and `pc` becomes 0xF0.
- R8: While a handler is active, `irq` is ignored: `irq_ack` stays low and `pc` follows the handler program.
- R9: Opcode 9 restores `pc` and `flags` from the saved copy at decode, skips the operand steps and re-enables interrupts.
- R10: `flags` takes the value of `alu_flags` in every data-operation phase and keeps it otherwise.
- R11: `mem_rd` is high exactly in fetch and operand fetch, and `mem_wr` exactly in store.
- R12: While `rst_n` is low, `phase` is 1 (next-address calculation), `pc` and `flags` are 0, and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rdata | input | 14 | Instruction word returned by memory |
| mem_ready | input | 1 | Memory or I/O ready for the current handshake step |
| irq | input | 1 | Interrupt request level |
| alu_flags | input | 4 | Flags produced by the datapath operation |
| phase | output | 9 | One-hot current step |
| mem_rd | output | 1 | Read strobe (fetch, operand fetch) |
| mem_wr | output | 1 | Write strobe (store) |
| pc | output | 8 | Program counter |
| flags | output | 4 | Flags register |
| irq_ack | output | 1 | Interrupt entry pulse |

## Verification
The assertions assume that `mem_ready` only has meaning in a handshake phase and that the instruction word is stable from the fetch handshake on. The bench raises ready only in fetch, operand fetch or store, after a chosen number of wait cycles, and holds the word and `irq` constant for each whole instruction. It sweeps every operand mode, counts 0 to 3 and waits 0 to 2, and rebuilds the expected per-cycle phase trace arithmetically. Jumps, interrupt entry, interrupts ignored in a handler, and returns are then run in sequence.

// File: rtl/ics_pkg.sv
package ics_pkg;

  typedef enum logic [3:0] {
    ST_IAC = 4'd0,
    ST_IF  = 4'd1,
    ST_IOD = 4'd2,
    ST_OAR = 4'd3,
    ST_OF  = 4'd4,
    ST_DO  = 4'd5,
    ST_OAW = 4'd6,
    ST_OS  = 4'd7,
    ST_INT = 4'd8
  } ics_state_e;

  localparam int NUM_ST = 9;

  localparam logic [3:0] OPC_JUMP = 4'h8;
  localparam logic [3:0] OPC_RETI = 4'h9;

  typedef struct packed {
    logic jump;
    logic reti;
    logic rd;
    logic wr;
  } ics_dec_t;

endpackage

// File: rtl/ics_decode.sv
module ics_decode
  import ics_pkg::*;
#(
  parameter int AW  = 8,
  parameter int OPW = 4,
  parameter int CW  = 4,
  parameter int IW  = OPW + 2 + AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ics_state_e    state,
  input  logic          mem_ready,
  input  logic [IW-1:0] mem_rdata,
  output ics_dec_t      dec,
  output logic [AW-1:0] target,
  output logic [CW-1:0] cnt_init
);

  logic [IW-1:0]  ir_q;
  logic           ir_en;
  logic [OPW-1:0] opc;
  logic [1:0]     mode;

  assign ir_en = (state == ST_IF) && mem_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ir_q <= '0;
    else if (ir_en) ir_q <= mem_rdata;
  end

  always_comb begin
    opc      = ir_q[IW-1 -: OPW];
    mode     = ir_q[AW +: 2];
    target   = ir_q[AW-1:0];
    cnt_init = ir_q[CW-1:0];
    dec.jump = (opc == OPW'(OPC_JUMP));
    dec.reti = (opc == OPW'(OPC_RETI));
    dec.rd   = mode[0];
    dec.wr   = mode[1];
  end

endmodule

// File: rtl/ics_fsm.sv
module ics_fsm
  import ics_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ics_dec_t      dec,
  input  logic [CW-1:0] cnt_init,
  input  logic          mem_ready,
  input  logic          irq,
  input  logic          in_isr,
  output ics_state_e    state,
  output logic          irq_take
);

  localparam logic [CW-1:0] ONE = CW'(1);

  ics_state_e    state_q, state_d;
  ics_state_e    first_op, after_elem;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          last_elem;

  always_comb begin
    last_elem  = (cnt_q == '0);
    first_op   = dec.rd ? ST_OAR : ST_DO;
    after_elem = last_elem ? ST_INT : first_op;
    irq_take   = (state_q == ST_INT) && irq && !in_isr;
    state_d    = state_q;
    cnt_en     = 1'b0;
    cnt_d      = cnt_q - ONE;
    unique case (state_q)
      ST_IAC: state_d = ST_IF;
      ST_IF:  if (mem_ready) state_d = ST_IOD;
      ST_IOD: begin
        cnt_en  = 1'b1;
        cnt_d   = cnt_init;
        state_d = (dec.jump || dec.reti) ? ST_INT : first_op;
      end
      ST_OAR: state_d = ST_OF;
      ST_OF:  if (mem_ready) state_d = ST_DO;
      ST_DO: begin
        if (dec.wr) begin
          state_d = ST_OAW;
        end else begin
          state_d = after_elem;
          cnt_en  = !last_elem;
        end
      end
      ST_OAW: state_d = ST_OS;
      ST_OS: begin
        if (mem_ready) begin
          state_d = after_elem;
          cnt_en  = !last_elem;
        end
      end
      ST_INT: state_d = ST_IAC;
      default: state_d = ST_IAC;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IAC;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state = state_q;

endmodule

// File: rtl/ics_ctx.sv
module ics_ctx
  import ics_pkg::*;
#(
  parameter int          AW         = 8,
  parameter int          FW         = 4,
  parameter int          PC_INC     = 1,
  parameter logic [AW-1:0] RESET_PC   = '0,
  parameter logic [AW-1:0] HANDLER_PC = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ics_state_e    state,
  input  logic          mem_ready,
  input  ics_dec_t      dec,
  input  logic [AW-1:0] target,
  input  logic [FW-1:0] alu_flags,
  input  logic          irq_take,
  output logic [AW-1:0] pc,
  output logic [FW-1:0] flags,
  output logic          in_isr
);

  localparam logic [AW-1:0] INC = AW'(PC_INC);

  logic [AW-1:0] pc_q, pc_d, shd_pc_q;
  logic [FW-1:0] fl_q, fl_d, shd_fl_q;
  logic          isr_q, isr_d;
  logic          pc_en, fl_en, isr_en;
  logic          at_iod, fetch_done;

  always_comb begin
    at_iod     = (state == ST_IOD);
    fetch_done = (state == ST_IF) && mem_ready;
    pc_en  = 1'b1;
    pc_d   = pc_q;
    if (irq_take)               pc_d = HANDLER_PC;
    else if (at_iod && dec.jump) pc_d = target;
    else if (at_iod && dec.reti) pc_d = shd_pc_q;
    else if (fetch_done)         pc_d = pc_q + INC;
    else                         pc_en = 1'b0;
    fl_en = 1'b1;
    fl_d  = fl_q;
    if (at_iod && dec.reti)  fl_d = shd_fl_q;
    else if (state == ST_DO) fl_d = alu_flags;
    else                     fl_en = 1'b0;
    isr_en = irq_take || (at_iod && dec.reti);
    isr_d  = irq_take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_PC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fl_q <= '0;
    else if (fl_en) fl_q <= fl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_pc_q <= '0;
      shd_fl_q <= '0;
    end else if (irq_take) begin
      shd_pc_q <= pc_q;
      shd_fl_q <= fl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      isr_q <= 1'b0;
    else if (isr_en) isr_q <= isr_d;
  end

  assign pc     = pc_q;
  assign flags  = fl_q;
  assign in_isr = isr_q;

endmodule

// File: rtl/instr_cycle_seq.sv
module instr_cycle_seq
  import ics_pkg::*;
#(
  parameter int            AW         = 8,
  parameter int            OPW        = 4,
  parameter int            CW         = 4,
  parameter int            FW         = 4,
  parameter int            PC_INC     = 1,
  parameter logic [AW-1:0] RESET_PC   = 8'h00,
  parameter logic [AW-1:0] HANDLER_PC = 8'hF0,
  parameter int            IW         = OPW + 2 + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IW-1:0]     mem_rdata,
  input  logic              mem_ready,
  input  logic              irq,
  input  logic [FW-1:0]     alu_flags,
  output logic [NUM_ST-1:0] phase,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [AW-1:0]     pc,
  output logic [FW-1:0]     flags,
  output logic              irq_ack
);

  logic [1:0]    rst_pipe;
  logic          rst_core_n;
  ics_state_e    state;
  ics_dec_t      dec;
  logic [AW-1:0] target;
  logic [CW-1:0] cnt_init;
  logic          irq_take;
  logic          in_isr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  ics_decode #(.AW(AW), .OPW(OPW), .CW(CW), .IW(IW)) u_decode (
    .clk(clk), .rst_n(rst_core_n), .state(state), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .dec(dec), .target(target), .cnt_init(cnt_init)
  );

  ics_fsm #(.CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_core_n), .dec(dec), .cnt_init(cnt_init),
    .mem_ready(mem_ready), .irq(irq), .in_isr(in_isr),
    .state(state), .irq_take(irq_take)
  );

  ics_ctx #(
    .AW(AW), .FW(FW), .PC_INC(PC_INC), .RESET_PC(RESET_PC), .HANDLER_PC(HANDLER_PC)
  ) u_ctx (
    .clk(clk), .rst_n(rst_core_n), .state(state), .mem_ready(mem_ready),
    .dec(dec), .target(target), .alu_flags(alu_flags), .irq_take(irq_take),
    .pc(pc), .flags(flags), .in_isr(in_isr)
  );

  for (genvar g = 0; g < NUM_ST; g++) begin : g_phase
    assign phase[g] = (state == ics_state_e'(g));
  end

  assign mem_rd  = (state == ST_IF) || (state == ST_OF);
  assign mem_wr  = (state == ST_OS);
  assign irq_ack = irq_take;

endmodule

// File: rtl/ics_chk.sv
module ics_chk
  import ics_pkg::*;
#(
  parameter int            AW         = 8,
  parameter int            PC_INC     = 1,
  parameter logic [AW-1:0] HANDLER_PC = 8'hF0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_ST-1:0] phase,
  input logic              mem_ready,
  input logic              mem_rd,
  input logic              mem_wr,
  input logic [AW-1:0]     pc,
  input logic              irq_ack
);

  localparam logic [AW-1:0] INC = AW'(PC_INC);

  // R1
  phase_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(phase) == 1);

  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[ST_IF] && !mem_ready) |=> phase[ST_IF]);

  // R4
  store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[ST_OS] && !mem_ready) |=> phase[ST_OS]);

  // R4
  addr_calc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase[ST_IAC] |=> phase[ST_IF]);

  // R3
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase[ST_IF] && mem_ready) |=> (pc == AW'($past(pc) + INC)));

  // R7
  ack_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> phase[ST_INT]);

  // R7
  ack_vector_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (pc == HANDLER_PC) && phase[ST_IAC]);

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

endmodule

bind instr_cycle_seq ics_chk #(
  .AW(AW), .PC_INC(PC_INC), .HANDLER_PC(HANDLER_PC)
) u_chk (
  .clk(clk), .rst_n(rst_core_n), .phase(phase), .mem_ready(mem_ready),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .pc(pc), .irq_ack(irq_ack)
);

// File: tb/instr_cycle_seq_bench.sv
`timescale 1ns/1ps
module instr_cycle_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [13:0] mem_rdata;
  logic        mem_ready;
  logic        irq;
  logic [3:0]  alu_flags;
  logic [8:0]  phase;
  logic        mem_rd, mem_wr;
  logic [7:0]  pc;
  logic [3:0]  flags;
  logic        irq_ack;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  int exp_t [64];
  int act_t [64];
  int ne, na, acks, strobe_err;

  always #4 clk = ~clk;

  instr_cycle_seq u_instr_cycle_seq (
    .clk(clk), .rst_n(rst_n), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .irq(irq), .alu_flags(alu_flags), .phase(phase), .mem_rd(mem_rd),
    .mem_wr(mem_wr), .pc(pc), .flags(flags), .irq_ack(irq_ack)
  );

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int ph_idx(input logic [8:0] p);
    int r = -1;
    for (int i = 0; i < 9; i++)
      if (p[i]) r = (r == -1) ? i : -2;
    return r;
  endfunction

  task automatic push(input int v);
    if (ne < 64) exp_t[ne] = v;
    ne++;
  endtask

  // Runs one instruction starting at a negedge in the address phase;
  // returns at the negedge after the interrupt-check cycle.
  task automatic run_instr(input logic [13:0] word, input int waits,
                           input logic irq_lvl, input logic [3:0] af,
                           input string tag);
    int wc = 0;
    bit fin = 0;
    int ph;
    int mism = -1;
    ne = 0; na = 0; acks = 0; strobe_err = 0;
    push(0);
    for (int i = 0; i <= waits; i++) push(1);
    push(2);
    if (word[13:10] != 4'h8 && word[13:10] != 4'h9) begin
      for (int e = 0; e <= int'(word[3:0]); e++) begin
        if (word[8]) begin
          push(3);
          for (int i = 0; i <= waits; i++) push(4);
        end
        push(5);
        if (word[9]) begin
          push(6);
          for (int i = 0; i <= waits; i++) push(7);
        end
      end
    end
    push(8);
    mem_rdata = word; irq = irq_lvl; alu_flags = af;
    while (!fin && na < 64) begin
      ph = ph_idx(phase);
      act_t[na] = ph; na++;
      if (irq_ack) acks++;
      if (mem_rd != (ph == 1 || ph == 4) || mem_wr != (ph == 7)) strobe_err++;
      if (ph == 1 || ph == 4 || ph == 7) begin
        mem_ready = (wc == waits);
        wc = (wc == waits) ? 0 : wc + 1;
      end else begin
        mem_ready = 1'b0;
        wc = 0;
      end
      if (ph == 8) fin = 1;
      @(negedge clk);
    end
    mem_ready = 1'b0;
    for (int i = 0; i < ne && i < na; i++)
      if (mism < 0 && act_t[i] != exp_t[i]) mism = i;
    chk({tag, " R2 R4 R5 trace length"}, na, ne);
    if (mism >= 0) chk({tag, " R2 R4 R5 trace step"}, act_t[mism], exp_t[mism]);
    else           chk({tag, " R1 R2 trace content"}, 0, 0);
    chk({tag, " R11 strobes"}, strobe_err, 0);
  endtask

  initial begin
    int exp_pc, exp_fl, save_pc, save_fl;
    logic [13:0] w;
    rst_n = 1'b0; mem_ready = 1'b0; irq = 1'b0; mem_rdata = '0; alu_flags = '0;
    repeat (3) @(negedge clk);
    chk("R12 reset phase", phase, 9'h001);
    chk("R12 reset pc", pc, 0);
    chk("R12 reset flags", flags, 0);
    chk("R12 reset strobes", {mem_rd, mem_wr, irq_ack}, 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    exp_pc = 0;
    // Sweep of modes, counts and memory waits (R2, R4, R5, R3, R10)
    for (int m = 0; m < 4; m++)
      for (int c = 0; c < 4; c++)
        for (int wt = 0; wt < 3; wt++) begin
          w = {4'h1, 2'(m), 4'h0, 4'(c)};
          exp_fl = (m * 4 + c + wt) % 16;
          run_instr(w, wt, 1'b0, 4'(exp_fl), "sweep");
          exp_pc = (exp_pc + 1) % 256;
          chk("R3 pc increment", pc, exp_pc);
          chk("R10 flags load", flags, exp_fl);
          chk("R7 no ack without irq", acks, 0);
        end
    // R6 jump, mode bits set but unused
    run_instr({4'h8, 2'b11, 8'h20}, 1, 1'b0, 4'h7, "jump");
    chk("R6 jump target", pc, 8'h20);
    chk("R10 flags kept over jump", flags, exp_fl);
    // R7 interrupt entry
    run_instr({4'h1, 2'b01, 8'h00}, 0, 1'b1, 4'hA, "irq");
    save_pc = 8'h21; save_fl = 4'hA;
    chk("R7 ack pulse", acks, 1);
    chk("R7 handler pc", pc, 8'hF0);
    // R8 irq ignored in handler
    run_instr({4'h1, 2'b11, 8'h01}, 1, 1'b1, 4'h5, "in-handler");
    chk("R8 no ack in handler", acks, 0);
    chk("R8 handler pc advances", pc, 8'hF1);
    chk("R10 flags in handler", flags, 4'h5);
    // R9 return
    run_instr({4'h9, 2'b10, 8'h00}, 2, 1'b0, 4'h3, "reti");
    chk("R9 pc restored", pc, save_pc);
    chk("R9 flags restored", flags, save_fl);
    // R9 re-enable: next irq accepted
    run_instr({4'h1, 2'b00, 8'h02}, 0, 1'b1, 4'h3, "irq2");
    chk("R9 interrupts re-enabled", acks, 1);
    chk("R7 handler pc again", pc, 8'hF0);
    save_pc = 8'h22; save_fl = 4'h3;
    // R6 jump in handler with irq held, R8 ignored
    run_instr({4'h8, 2'b00, 8'h40}, 0, 1'b1, 4'h9, "jump-isr");
    chk("R6 jump in handler", pc, 8'h40);
    chk("R8 ack suppressed on jump", acks, 0);
    run_instr({4'h9, 2'b00, 8'h00}, 0, 1'b0, 4'h9, "reti2");
    chk("R9 second return pc", pc, save_pc);
    chk("R9 second return flags", flags, save_fl);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule